// File: doc/BRIEF.md
# Serial Bus Slave Header Decoder

This block sits on the receive side of a unit attached to a bit-serial, multi-drop bus. It follows the header of each frame one bit slot at a time: first the destination address with its parity bit and an acknowledge slot, then the control code with its parity bit and a second acknowledge slot. A strobe marks each bit slot and carries the received bit. The block decides whether this unit is being addressed and whether it can serve the requested control code. It pulls its acknowledge output low for the matching slots.

Broadcast frames are flagged by an indicator input that is captured at frame start. For these frames the destination address is read as a broadcast class. The all-ones address is a general broadcast. Any other value names a group through its upper four bits. On a broadcast the unit never drives an acknowledge, but it still follows the control field and reports acceptance. After any refusal the block goes back to monitoring and ignores the bus until the next frame start.

Top module: `hdr_slave_decoder`

## Requirements
- R1: The address is taken in over 12 strobes, most significant bit first, and then one parity bit. Parity is even: the 12 bits and the parity bit together hold an even number of ones. On a non-broadcast frame whose address equals `own_addr` with correct parity, `ack_drv` goes to 0 in the clock after the parity strobe.
- R2: An address that does not match, or that has an even-parity error, gets no acknowledge. The block then gives no acceptance and ignores every further strobe until the next `frame_start`.
- R3: `ack_drv` is 1 except while an acknowledge is driven. It falls only in the clock after a strobe, and it returns to 1 in the clock after the next strobe, which is the acknowledge slot. So it is held low for exactly one bit slot.
- R4: On a broadcast frame with address 0xFFF and correct parity, `is_general` is 1 and `group_num` is 0xF from the clock after the address parity strobe until the next `frame_start`. `is_group` stays 0.
- R5: On a broadcast frame with any other address, the frame is taken when its upper 4 bits equal `own_addr[11:8]` and its parity is correct. `is_group` is then 1 and `group_num` holds those 4 bits. Otherwise the frame is refused. A broadcast frame never drives `ack_drv` to 0.
- R6: After the address acknowledge slot, a 4-bit control code is taken most significant bit first, followed by one even-parity bit. If the parity is correct and `func_mask[code]` is 1, then in the clock after the parity strobe `accept` pulses high for one clock and `ctrl_code` shows the code. On a non-broadcast frame `ack_drv` also goes to 0 at that time.
- R7: If the control parity is wrong or `func_mask[code]` is 0, there is no acknowledge and no `accept` pulse. The block goes back to monitoring.
- R8: After reset, `ack_drv` is 1, `accept` is 0, `ctrl_code` is 0, both broadcast flags are 0 and `group_num` is 0.
- R9: `frame_start` restarts reception from the first address bit in any state. It samples `bcast_in`, clears both broadcast flags and releases `ack_drv` in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-clock strobe per bit slot |
| bit_in | input | 1 | Received bit, valid with `bit_stb` |
| frame_start | input | 1 | Pulse that begins a new header |
| bcast_in | input | 1 | Broadcast indicator, captured at `frame_start` |
| own_addr | input | 12 | This unit's address; upper 4 bits are its group |
| func_mask | input | 16 | One bit per control code, 1 = supported |
| ack_drv | output | 1 | Acknowledge drive, 0 = acknowledge, 1 = released |
| accept | output | 1 | One-clock pulse when the control field is accepted |
| ctrl_code | output | 4 | Accepted control code |
| is_general | output | 1 | General broadcast taken |
| is_group | output | 1 | Group broadcast taken |
| group_num | output | 4 | Group number of the taken broadcast |

## Verification
The assertions assume a few things about the inputs. `own_addr` and `func_mask` stay steady while a frame is being received, and `frame_start` never arrives in the same clock as a strobe. Strobes are single-clock pulses separated by at least one idle clock. The stimulus keeps to these rules in four ways: it pulses `frame_start` on its own clock, changes the configuration only in the clock after it, drives each strobe for one clock and then leaves one idle clock. Random frames mix matching and foreign addresses, broadcast classes, parity faults and masks, and directed frames cover the corner cases.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_APAR,
    ST_AACK,
    ST_CTRL,
    ST_CPAR,
    ST_CACK
  } hdr_state_t;
endpackage

// File: rtl/hdr_shifter.sv
module hdr_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         d,
  output logic [W-1:0] q,
  output logic         par
);
  // shift in MSB first, running XOR of data bits
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q   <= '0;
      par <= 1'b0;
    end else if (en) begin
      q   <= {q[W-2:0], d};
      par <= par ^ d;
    end
  end
endmodule

// File: rtl/hdr_addr_match.sv
module hdr_addr_match #(
  parameter int ADDR_W = 12,
  parameter int GRP_W  = 4
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              bcast,
  output logic              hit,
  output logic              general,
  output logic              group
);
  localparam int GLO = ADDR_W - GRP_W;

  always_comb begin
    general = bcast && (&rx_addr);
    group   = bcast && !(&rx_addr) &&
              (rx_addr[ADDR_W-1:GLO] == own_addr[ADDR_W-1:GLO]);
    hit     = bcast ? (general || group) : (rx_addr == own_addr);
  end
endmodule

// File: rtl/hdr_slave_decoder.sv
module hdr_slave_decoder #(
  parameter int ADDR_W = 12,
  parameter int CTRL_W = 4,
  parameter int GRP_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_stb,
  input  logic                   bit_in,
  input  logic                   frame_start,
  input  logic                   bcast_in,
  input  logic [ADDR_W-1:0]      own_addr,
  input  logic [(1<<CTRL_W)-1:0] func_mask,
  output logic                   ack_drv,
  output logic                   accept,
  output logic [CTRL_W-1:0]      ctrl_code,
  output logic                   is_general,
  output logic                   is_group,
  output logic [GRP_W-1:0]       group_num
);
  import hdr_pkg::*;

  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam int GLO   = ADDR_W - GRP_W;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);

  hdr_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             bcast_q;
  logic [ADDR_W-1:0] sh_q;
  logic             sh_par;
  logic             sh_clr, sh_en;
  logic             m_hit, m_gen, m_grp;
  logic             par_ok;
  logic             code_ok;

  assign sh_clr  = frame_start || (bit_stb && state == ST_AACK);
  assign sh_en   = bit_stb && (state == ST_ADDR || state == ST_CTRL);
  assign par_ok  = (sh_par ^ bit_in) == 1'b0;
  assign code_ok = func_mask[sh_q[CTRL_W-1:0]];

  hdr_shifter #(.W(ADDR_W)) u_shift (
    .clk (clk),
    .rst (rst),
    .clr (sh_clr),
    .en  (sh_en),
    .d   (bit_in),
    .q   (sh_q),
    .par (sh_par)
  );

  hdr_addr_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .rx_addr  (sh_q),
    .own_addr (own_addr),
    .bcast    (bcast_q),
    .hit      (m_hit),
    .general  (m_gen),
    .group    (m_grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bcast_q    <= 1'b0;
      ack_drv    <= 1'b1;
      accept     <= 1'b0;
      ctrl_code  <= '0;
      is_general <= 1'b0;
      is_group   <= 1'b0;
      group_num  <= '0;
    end else begin
      accept <= 1'b0;
      if (frame_start) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        bcast_q    <= bcast_in;
        ack_drv    <= 1'b1;
        is_general <= 1'b0;
        is_group   <= 1'b0;
        group_num  <= '0;
      end else if (bit_stb) begin
        unique case (state)
          ST_ADDR: begin
            cnt <= cnt + 1'b1;
            if (cnt == ADDR_LAST) state <= ST_APAR;
          end
          ST_APAR: begin
            if (par_ok && m_hit) begin
              state      <= ST_AACK;
              ack_drv    <= bcast_q;
              is_general <= m_gen;
              is_group   <= m_grp;
              if (bcast_q) group_num <= sh_q[ADDR_W-1:GLO];
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_AACK: begin
            ack_drv <= 1'b1;
            cnt     <= '0;
            state   <= ST_CTRL;
          end
          ST_CTRL: begin
            cnt <= cnt + 1'b1;
            if (cnt == CTRL_LAST) state <= ST_CPAR;
          end
          ST_CPAR: begin
            if (par_ok && code_ok) begin
              state     <= ST_CACK;
              ack_drv   <= bcast_q;
              accept    <= 1'b1;
              ctrl_code <= sh_q[CTRL_W-1:0];
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_CACK: begin
            ack_drv <= 1'b1;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdr_slave_checker.sv
module hdr_slave_checker #(
  parameter int ADDR_W = 12,
  parameter int CTRL_W = 4,
  parameter int GRP_W  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bit_stb,
  input logic                   frame_start,
  input logic [ADDR_W-1:0]      own_addr,
  input logic [(1<<CTRL_W)-1:0] func_mask,
  input logic                   ack_drv,
  input logic                   accept,
  input logic [CTRL_W-1:0]      ctrl_code,
  input logic                   is_general,
  input logic                   is_group,
  input logic [GRP_W-1:0]       group_num
);
  logic [(1<<CTRL_W)-1:0] mask_prev;
  always_ff @(posedge clk) mask_prev <= func_mask;

  p_ack_falls_on_stb_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_drv) |-> $past(bit_stb));

  p_ack_one_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (!ack_drv && (bit_stb || frame_start)) |=> ack_drv);

  p_accept_supported_r6: assert property (@(posedge clk) disable iff (rst)
    accept |-> mask_prev[ctrl_code]);

  p_accept_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(is_general && is_group));

  p_general_num_r4: assert property (@(posedge clk) disable iff (rst)
    is_general |-> (&group_num));

  p_group_num_r5: assert property (@(posedge clk) disable iff (rst)
    is_group |-> group_num == own_addr[ADDR_W-1:ADDR_W-GRP_W]);

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!is_general && !is_group && ack_drv));
endmodule

bind hdr_slave_decoder hdr_slave_checker #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .GRP_W(GRP_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_start(frame_start),
  .own_addr(own_addr), .func_mask(func_mask), .ack_drv(ack_drv),
  .accept(accept), .ctrl_code(ctrl_code), .is_general(is_general),
  .is_group(is_group), .group_num(group_num)
);

// File: tb/sim_hdr_slave_decoder.sv
`timescale 1ns/1ps
module sim_hdr_slave_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_stb = 1'b0, bit_in = 1'b0;
  logic        frame_start = 1'b0, bcast_in = 1'b0;
  logic [11:0] own_addr = 12'h3A5;
  logic [15:0] func_mask = 16'hFFFF;
  logic        ack_drv, accept, is_general, is_group;
  logic [3:0]  ctrl_code, group_num;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hdr_slave_decoder u0 (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .frame_start(frame_start), .bcast_in(bcast_in), .own_addr(own_addr),
    .func_mask(func_mask), .ack_drv(ack_drv), .accept(accept),
    .ctrl_code(ctrl_code), .is_general(is_general), .is_group(is_group),
    .group_num(group_num)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_hit(input bit bc, input logic [11:0] a, input logic [11:0] own);
    if (!bc) return a == own;
    return (a == 12'hFFF) || (a[11:8] == own[11:8]);
  endfunction

  task automatic strobe(input logic b);
    @(negedge clk); bit_stb = 1'b1; bit_in = b;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic start(input bit bc, input logic [11:0] own, input logic [15:0] mask);
    @(negedge clk); frame_start = 1'b1; bcast_in = bc;
    @(negedge clk); frame_start = 1'b0; own_addr = own; func_mask = mask;
    check("R9 flags cleared", {14'd0, is_general, is_group}, 16'd0);
  endtask

  task automatic do_frame(input bit bc, input logic [11:0] own, input logic [15:0] mask,
                          input logic [11:0] a, input bit abad,
                          input logic [3:0] c, input bit cbad);
    bit aok, cok;
    start(bc, own, mask);
    for (int i = 11; i >= 0; i--) strobe(a[i]);
    check("R3 idle ack", {15'd0, ack_drv}, 16'd1);
    strobe((^a) ^ abad);
    aok = exp_hit(bc, a, own) && !abad;
    check(bc ? "R5 addr ack" : (aok ? "R1 addr ack" : "R2 addr refuse"),
          {15'd0, ack_drv}, {15'd0, !(aok && !bc)});
    check("R4 general", {15'd0, is_general}, {15'd0, aok && bc && a == 12'hFFF});
    check("R5 group", {15'd0, is_group}, {15'd0, aok && bc && a != 12'hFFF});
    check("R5 group_num", {12'd0, group_num}, {12'd0, (aok && bc) ? a[11:8] : 4'd0});
    strobe(1'b1);
    check("R3 ack released", {15'd0, ack_drv}, 16'd1);
    for (int i = 3; i >= 0; i--) strobe(c[i]);
    strobe((^c) ^ cbad);
    cok = aok && !cbad && mask[c];
    check(cok ? "R6 accept" : (aok ? "R7 refuse" : "R2 ignored"),
          {15'd0, accept}, {15'd0, cok});
    check("R6 ctrl ack", {15'd0, ack_drv}, {15'd0, !(cok && !bc)});
    if (cok) check("R6 ctrl_code", {12'd0, ctrl_code}, {12'd0, c});
    strobe(1'b1);
    check("R3 ctrl ack released", {15'd0, ack_drv}, 16'd1);
    check("R6 single pulse", {15'd0, accept}, 16'd0);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed;
    logic [11:0] own, a;
    logic [15:0] mask;
    logic [3:0] c;
    bit bc;
    seed = $urandom(1234);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ack", {15'd0, ack_drv}, 16'd1);
    check("R8 accept", {15'd0, accept}, 16'd0);
    check("R8 flags", {12'd0, ctrl_code}, 16'd0);
    check("R8 bcast", {12'd0, is_general, is_group, 2'b00}, 16'd0);
    check("R8 group_num", {12'd0, group_num}, 16'd0);

    do_frame(0, 12'h3A5, 16'hFFFF, 12'h3A5, 0, 4'h9, 0);
    do_frame(0, 12'h3A5, 16'hFFFF, 12'h3A5, 1, 4'h9, 0);
    do_frame(0, 12'h3A5, 16'hFFFF, 12'h3A4, 0, 4'h9, 0);
    do_frame(0, 12'h3A5, 16'hFFDF, 12'h3A5, 0, 4'h5, 0);
    do_frame(0, 12'h3A5, 16'hFFFF, 12'h3A5, 0, 4'h5, 1);
    do_frame(1, 12'h3A5, 16'hFFFF, 12'hFFF, 0, 4'h2, 0);
    do_frame(1, 12'h3A5, 16'hFFFF, 12'h30C, 0, 4'h2, 0);
    do_frame(1, 12'h3A5, 16'hFFFF, 12'h40C, 0, 4'h2, 0);
    do_frame(1, 12'h3A5, 16'hFFFF, 12'hFFF, 1, 4'h2, 0);

    start(0, 12'h123, 16'hFFFF);
    for (int i = 0; i < 5; i++) strobe(1'b1);
    do_frame(0, 12'h123, 16'h0001, 12'h123, 0, 4'h0, 0);

    for (int k = 0; k < 300; k++) begin
      own  = 12'($urandom);
      mask = 16'($urandom);
      bc   = ($urandom % 10) < 3;
      case ($urandom % 4)
        0: a = 12'hFFF;
        1: a = {own[11:8], 8'($urandom)};
        2: a = 12'($urandom);
        default: a = own;
      endcase
      c = 4'($urandom);
      do_frame(bc, own, mask, a, ($urandom % 8) == 0, c, ($urandom % 8) == 0);
    end
    summary();
  end
endmodule